// File: doc/BRIEF.md
# Block Cipher Chaining Mode Unit

This unit sits in front of a 64-bit block cipher engine and turns it into a complete encrypt/decrypt path. It supports four modes of operation: electronic codebook, cipher block chaining, 1-bit cipher feedback and 8-bit cipher feedback. The round logic of the cipher is not part of the unit. The unit reaches the engine through a start/done handshake. It sends the engine a 64-bit block and a direction, and it takes back a 64-bit result.

The unit keeps one chaining vector for the encrypt direction and one for the decrypt direction. Each direction has a loaded base value and a working copy. The working copy advances as blocks, bytes or bits pass through. In the feedback modes the working copy serves as the shift register: the engine encrypts it, the leftmost bits of the engine output form the keystream, and the ciphertext shifts in at the right.

A caller presents one item at a time with `in_valid_i` while `in_ready_o` is high. The unit returns a one-cycle `out_valid_o` pulse with the result. Loading a vector, or changing the mode, puts the chaining back to the loaded base.

Top module: `cipher_mode_unit`

## Requirements
- R1: After reset `in_ready_o` is 1, `out_valid_o` and `eng_start_o` are 0, and both chaining vectors are zero.
- R2: With `mode_i` = 0 (codebook), the engine input is the input block and the engine direction follows `dir_i` (0 encrypt, 1 decrypt). The result is the engine output, and no chaining state changes, so equal inputs give equal outputs.
- R3: With `mode_i` = 1 (chaining) and `dir_i` = 0, the engine encrypts the input XOR the encrypt vector. The result is the engine output, which then becomes the encrypt vector, so a repeated plaintext block gives a different ciphertext.
- R4: With `mode_i` = 1 and `dir_i` = 1, the engine decrypts the input block. The result is the engine output XOR the decrypt vector, and the incoming block then becomes the decrypt vector.
- R5: In both feedback modes (`mode_i` = 2 or 3) the engine is always started with `eng_decrypt_o` = 0, and its input is the working vector of the selected direction.
- R6: With `mode_i` = 3, the result is `in_data_i[7:0]` XOR engine output bits [63:56], returned in `out_data_o[7:0]` with bits [63:8] zero. Input bits [63:8] are ignored. The vector shifts left by 8 and takes the ciphertext byte in at bits [7:0].
- R7: With `mode_i` = 2, the result is `in_data_i[0]` XOR engine output bit 63, returned in `out_data_o[0]` with the other bits zero. The vector shifts left by 1 and takes the ciphertext bit in at bit 0.
- R8: The encrypt and decrypt vectors are independent. Traffic in one direction never changes the vector of the other.
- R9: A change of `mode_i` puts the working copy of both vectors back to their last loaded values.
- R10: `iv_load_i` writes `iv_data_i` into the vector selected by `iv_dir_i` (0 encrypt, 1 decrypt). When it coincides with a chaining update of the same direction, the loaded value wins.
- R11: Each accepted item gives exactly one single-cycle `eng_start_o` and exactly one single-cycle `out_valid_o`. `in_ready_o` is 0 from acceptance until the result is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 0 codebook, 1 chaining, 2 1-bit feedback, 3 8-bit feedback |
| dir_i | input | 1 | 0 encrypt, 1 decrypt |
| iv_load_i | input | 1 | Load a chaining vector |
| iv_dir_i | input | 1 | Vector selected by a load (0 encrypt, 1 decrypt) |
| iv_data_i | input | 64 | Vector value to load |
| in_valid_i | input | 1 | Input item present |
| in_ready_o | output | 1 | Unit idle, item accepted when valid |
| in_data_i | input | 64 | Block, byte [7:0] or bit [0] |
| out_valid_o | output | 1 | One-cycle result strobe |
| out_data_o | output | 64 | Result |
| eng_start_o | output | 1 | Engine start pulse |
| eng_decrypt_o | output | 1 | Engine direction |
| eng_data_o | output | 64 | Engine input block |
| eng_done_i | input | 1 | Engine result valid |
| eng_data_i | input | 64 | Engine output block |

## Verification
The conflict of interest is a vector load that lands in the same cycle as the chaining update that ends a block. To create it, the stand-in engine raises `iv_load_i` for the encrypt direction in the very cycle it raises `eng_done_i`. The result in flight must still be computed from the old vector. The following chaining block must then be enciphered against the newly loaded value, not against the ciphertext just produced, and the bench checks that value against one it derives on its own.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
  typedef enum logic [1:0] {
    MODE_ECB  = 2'd0,
    MODE_CBC  = 2'd1,
    MODE_CFB1 = 2'd2,
    MODE_CFB8 = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WAIT  = 2'd2
  } state_e;
endpackage

// File: rtl/cmu_ctrl.sv
module cmu_ctrl
  import cmu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic eng_done,
  output logic in_ready,
  output logic accept,
  output logic eng_start,
  output logic finish,
  output logic out_valid
);
  state_e state_q, state_d;
  logic   out_valid_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (in_valid) state_d = ST_START;
      ST_START: state_d = ST_WAIT;
      ST_WAIT:  if (eng_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      out_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      out_valid_q <= finish;
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign accept    = in_ready && in_valid;
  assign eng_start = (state_q == ST_START);
  assign finish    = (state_q == ST_WAIT) && eng_done;
  assign out_valid = out_valid_q;
endmodule

// File: rtl/cmu_ivbank.sv
module cmu_ivbank #(
  parameter int W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                load_dir,
  input  logic [W-1:0]        load_data,
  input  logic                restore,
  input  logic                upd,
  input  logic                upd_dir,
  input  logic [W-1:0]        upd_data,
  output logic [1:0][W-1:0]   work
);
  localparam int NDIR = 2;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic [W-1:0] base_q, base_d, work_q, work_d;
    logic         hit_load, hit_upd;

    assign hit_load = load && (load_dir == d[0]);
    assign hit_upd  = upd && (upd_dir == d[0]);

    always_comb begin
      base_d = base_q;
      work_d = work_q;
      if (hit_load) begin
        base_d = load_data;
        work_d = load_data;
      end else if (restore) begin
        work_d = base_q;
      end else if (hit_upd) begin
        work_d = upd_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        work_q <= '0;
      end else begin
        base_q <= base_d;
        work_q <= work_d;
      end
    end

    assign work[d] = work_q;
  end
endmodule

// File: rtl/cmu_datapath.sv
module cmu_datapath
  import cmu_pkg::*;
#(
  parameter int W   = 64,
  parameter int SEG = 8
) (
  input  mode_e          mode,
  input  logic           dir,
  input  logic [W-1:0]   req_data,
  input  logic [W-1:0]   req_iv,
  input  logic [W-1:0]   eng_result,
  output logic [W-1:0]   eng_in,
  output logic           eng_dec,
  output logic [W-1:0]   result,
  output logic [W-1:0]   next_iv
);
  logic [SEG-1:0] ks_seg, o_seg, c_seg;
  logic           ks_bit, o_bit, c_bit;

  assign ks_seg = eng_result[W-1 -: SEG];
  assign o_seg  = req_data[SEG-1:0] ^ ks_seg;
  assign c_seg  = dir ? req_data[SEG-1:0] : o_seg;
  assign ks_bit = eng_result[W-1];
  assign o_bit  = req_data[0] ^ ks_bit;
  assign c_bit  = dir ? req_data[0] : o_bit;

  always_comb begin
    eng_in  = req_iv;
    eng_dec = 1'b0;
    result  = eng_result;
    next_iv = req_iv;
    case (mode)
      MODE_ECB: begin
        eng_in  = req_data;
        eng_dec = dir;
      end
      MODE_CBC: begin
        eng_dec = dir;
        if (dir) begin
          eng_in  = req_data;
          result  = eng_result ^ req_iv;
          next_iv = req_data;
        end else begin
          eng_in  = req_data ^ req_iv;
          next_iv = eng_result;
        end
      end
      MODE_CFB1: begin
        result  = {{(W-1){1'b0}}, o_bit};
        next_iv = {req_iv[W-2:0], c_bit};
      end
      default: begin
        result  = {{(W-SEG){1'b0}}, o_seg};
        next_iv = {req_iv[W-SEG-1:0], c_seg};
      end
    endcase
  end
endmodule

// File: rtl/cipher_mode_unit.sv
module cipher_mode_unit
  import cmu_pkg::*;
#(
  parameter int W   = 64,
  parameter int SEG = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          dir_i,
  input  logic          iv_load_i,
  input  logic          iv_dir_i,
  input  logic [W-1:0]  iv_data_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [W-1:0]  in_data_i,
  output logic          out_valid_o,
  output logic [W-1:0]  out_data_o,
  output logic          eng_start_o,
  output logic          eng_decrypt_o,
  output logic [W-1:0]  eng_data_o,
  input  logic          eng_done_i,
  input  logic [W-1:0]  eng_data_i
);
  logic             accept, finish, restore;
  mode_e            req_mode_q, prev_mode_q;
  logic             req_dir_q;
  logic [W-1:0]     req_data_q, req_iv_q, out_data_q;
  logic [W-1:0]     result, next_iv;
  logic [1:0][W-1:0] iv_work;

  cmu_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid_i),
    .eng_done  (eng_done_i),
    .in_ready  (in_ready_o),
    .accept    (accept),
    .eng_start (eng_start_o),
    .finish    (finish),
    .out_valid (out_valid_o)
  );

  assign restore = (mode_e'(mode_i) != prev_mode_q);

  cmu_ivbank #(.W(W)) u_iv (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (iv_load_i),
    .load_dir  (iv_dir_i),
    .load_data (iv_data_i),
    .restore   (restore),
    .upd       (finish),
    .upd_dir   (req_dir_q),
    .upd_data  (next_iv),
    .work      (iv_work)
  );

  cmu_datapath #(.W(W), .SEG(SEG)) u_dp (
    .mode       (req_mode_q),
    .dir        (req_dir_q),
    .req_data   (req_data_q),
    .req_iv     (req_iv_q),
    .eng_result (eng_data_i),
    .eng_in     (eng_data_o),
    .eng_dec    (eng_decrypt_o),
    .result     (result),
    .next_iv    (next_iv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_mode_q <= MODE_ECB;
    end else begin
      prev_mode_q <= mode_e'(mode_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_mode_q <= MODE_ECB;
      req_dir_q  <= 1'b0;
      req_data_q <= '0;
      req_iv_q   <= '0;
    end else if (accept) begin
      req_mode_q <= mode_e'(mode_i);
      req_dir_q  <= dir_i;
      req_data_q <= in_data_i;
      req_iv_q   <= iv_work[dir_i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data_q <= '0;
    end else if (finish) begin
      out_data_q <= result;
    end
  end

  assign out_data_o = out_data_q;
endmodule

// File: rtl/cmu_checker.sv
module cmu_checker
  import cmu_pkg::*;
#(
  parameter int W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              eng_start_o,
  input logic              eng_decrypt_o,
  input logic              iv_load_i,
  input logic              iv_dir_i,
  input logic [W-1:0]      iv_data_i,
  input mode_e             req_mode_q,
  input logic [1:0][W-1:0] iv_work
);
  a_r11_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |=> !eng_start_o);

  a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |-> !in_ready_o);

  a_r11_out_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |=> !out_valid_o);

  a_r5_feedback_encrypts: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start_o && (req_mode_q == MODE_CFB1 || req_mode_q == MODE_CFB8)) |-> !eng_decrypt_o);

  a_r10_load_enc_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (iv_load_i && !iv_dir_i) |=> (iv_work[0] == $past(iv_data_i)));

  a_r10_load_dec_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (iv_load_i && iv_dir_i) |=> (iv_work[1] == $past(iv_data_i)));
endmodule

bind cipher_mode_unit cmu_checker #(.W(W)) u_chk (.*);

// File: tb/sim_cipher_mode_unit.sv
module sim_cipher_mode_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] KEY = 64'hA5C3_0F19_7E24_D6B8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        dir_i = 1'b0;
  logic        iv_load_i = 1'b0;
  logic        iv_dir_i = 1'b0;
  logic [63:0] iv_data_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [63:0] in_data_i = '0;
  logic        out_valid_o;
  logic [63:0] out_data_o;
  logic        eng_start_o, eng_decrypt_o;
  logic [63:0] eng_data_o;
  logic        eng_done_i = 1'b0;
  logic [63:0] eng_data_i = '0;

  int checks = 0, errors = 0;
  bit done_flag = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] cap[$];
  logic [63:0] m_base[2], m_work[2];
  logic [1:0]  cur_mode = 2'd0;
  bit          load_at_done = 0;
  logic [63:0] ld_val = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cipher_mode_unit u0 (.*);

  function automatic logic [63:0] f_enc(logic [63:0] x);
    return {x[50:0], x[63:51]} ^ KEY;
  endfunction

  function automatic logic [63:0] f_dec(logic [63:0] y);
    logic [63:0] z;
    z = y ^ KEY;
    return {z[12:0], z[63:13]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_step(logic [1:0] m, logic d, logic [63:0] x);
    logic [63:0] r, iv, k;
    logic o;
    logic [7:0] o8;
    iv = m_work[d];
    k = f_enc(iv);
    case (m)
      2'd0: r = d ? f_dec(x) : f_enc(x);
      2'd1: if (!d) begin r = f_enc(x ^ iv); iv = r; end
            else begin r = f_dec(x) ^ iv; iv = x; end
      2'd2: begin o = x[0] ^ k[63]; r = {63'b0, o}; iv = {iv[62:0], d ? x[0] : o}; end
      default: begin o8 = x[7:0] ^ k[63:56]; r = {56'b0, o8}; iv = {iv[55:0], d ? x[7:0] : o8}; end
    endcase
    m_work[d] = iv;
    return r;
  endfunction

  task automatic send(input logic [63:0] d, input logic [63:0] exp, input bit use_exp, input string tag);
    logic [63:0] m;
    while (!in_ready_o) @(negedge clk);
    m = model_step(cur_mode, dir_i, d);
    exp_q.push_back(use_exp ? exp : m);
    tag_q.push_back(tag);
    in_valid_i = 1'b1;
    in_data_i  = d;
    @(negedge clk);
    in_valid_i = 1'b0;
    while (!in_ready_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode_i = m;
    if (m != cur_mode) begin
      m_work[0] = m_base[0];
      m_work[1] = m_base[1];
    end
    cur_mode = m;
    @(negedge clk);
  endtask

  task automatic load_iv(input logic d, input logic [63:0] v);
    @(negedge clk);
    iv_load_i = 1'b1; iv_dir_i = d; iv_data_i = v;
    @(negedge clk);
    iv_load_i = 1'b0;
    m_base[d] = v;
    m_work[d] = v;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // stand-in engine
  initial begin
    logic [63:0] x;
    logic dec;
    forever begin
      @(negedge clk);
      if (eng_start_o) begin
        x = eng_data_o;
        dec = eng_decrypt_o;
        chk(in_ready_o == 1'b0, "R11 ready low while busy", {63'b0, in_ready_o}, 64'd0);
        if (cur_mode[1]) chk(dec == 1'b0, "R5 feedback engine direction", {63'b0, dec}, 64'd0);
        repeat (2) @(negedge clk);
        eng_done_i = 1'b1;
        eng_data_i = dec ? f_dec(x) : f_enc(x);
        if (load_at_done) begin
          iv_load_i = 1'b1; iv_dir_i = 1'b0; iv_data_i = ld_val;
          m_base[0] = ld_val; m_work[0] = ld_val;
          load_at_done = 0;
        end
        @(negedge clk);
        eng_done_i = 1'b0;
        iv_load_i = 1'b0;
      end
    end
  end

  // monitor
  initial begin
    logic [63:0] e;
    string t;
    forever begin
      @(negedge clk);
      if (out_valid_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11 unexpected result", out_data_o, 64'd0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_data_o === e, t, out_data_o, e);
          cap.push_back(out_data_o);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    logic [63:0] pa, pb, pc, ia, ib, ic, e;
    logic [7:0]  bytes[4];
    logic [7:0]  bits;
    pa = 64'h2020_2020_2020_2020;
    pb = 64'h0123_4567_89AB_CDEF;
    pc = 64'hFEDC_BA98_7654_3210;
    ia = 64'h1357_9BDF_0246_8ACE;
    ib = 64'hC0DE_FACE_B00C_1234;
    ic = 64'h0F0F_1E1E_2D2D_3C3C;
    m_base[0] = '0; m_base[1] = '0; m_work[0] = '0; m_work[1] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(in_ready_o === 1'b1, "R1 ready", {63'b0, in_ready_o}, 64'd1);
    chk(out_valid_o === 1'b0, "R1 out_valid", {63'b0, out_valid_o}, 64'd0);
    chk(eng_start_o === 1'b0, "R1 eng_start", {63'b0, eng_start_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: vectors reset to zero: chaining encrypt with zero vector
    set_mode(2'd1);
    dir_i = 1'b0;
    send(pb, f_enc(pb), 1, "R1 zero vector after reset");

    // R3 / R4 / R8 chaining round trip
    load_iv(1'b0, ia);
    load_iv(1'b1, ia);
    cap.delete();
    send(pa, f_enc(pa ^ ia), 1, "R3 first chained block");
    send(pa, '0, 0, "R3 second chained block");
    chk(cap[0] !== cap[1], "R3 repeated plaintext differs", cap[1], cap[0]);
    dir_i = 1'b1;
    send(cap[0], pa, 1, "R4 R8 chained decrypt block 0");
    send(cap[1], pa, 1, "R4 R8 chained decrypt block 1");

    // R2 codebook
    set_mode(2'd0);
    dir_i = 1'b0;
    cap.delete();
    send(pc, f_enc(pc), 1, "R2 codebook encrypt");
    send(pc, f_enc(pc), 1, "R2 codebook repeat");
    chk(cap[0] === cap[1], "R2 equal blocks equal output", cap[1], cap[0]);
    dir_i = 1'b1;
    send(cap[0], pc, 1, "R2 codebook decrypt");

    // R9 mode change restores the loaded vector
    set_mode(2'd1);
    dir_i = 1'b0;
    send(pa, f_enc(pa ^ ia), 1, "R9 restored encrypt vector");
    set_mode(2'd3);
    set_mode(2'd1);
    send(pa, f_enc(pa ^ ia), 1, "R9 restored again after mode toggle");

    // R10 load coinciding with the chaining update
    ld_val = ib;
    load_at_done = 1;
    send(pb, f_enc(pb ^ f_enc(pa ^ ia)), 1, "R10 in-flight result uses old vector");
    send(pc, f_enc(pc ^ ib), 1, "R10 loaded vector wins over update");

    // R6 8-bit feedback round trip, upper input bits ignored
    set_mode(2'd3);
    load_iv(1'b0, ic);
    load_iv(1'b1, ic);
    dir_i = 1'b0;
    bytes[0] = 8'h48; bytes[1] = 8'h69; bytes[2] = 8'h21; bytes[3] = 8'h00;
    cap.delete();
    e = f_enc(ic);
    send({56'hDEAD_BEEF_0000_77, bytes[0]}, {56'b0, bytes[0] ^ e[63:56]}, 1, "R6 first byte keystream");
    for (int i = 1; i < 4; i++) send({56'hFFFF_FFFF_FFFF_FF, bytes[i]}, '0, 0, "R6 feedback byte encrypt");
    dir_i = 1'b1;
    for (int i = 0; i < 4; i++) send({56'h1234_5678_9ABC_DE, cap[i][7:0]}, {56'b0, bytes[i]}, 1, "R6 R8 feedback byte decrypt");

    // R7 1-bit feedback round trip
    set_mode(2'd2);
    load_iv(1'b0, ia);
    load_iv(1'b1, ia);
    dir_i = 1'b0;
    bits = 8'b1011_0010;
    cap.delete();
    e = f_enc(ia);
    send({63'h7FFF_FFFF_FFFF_FFFE >> 1, bits[0]}, {63'b0, bits[0] ^ e[63]}, 1, "R7 first bit keystream");
    for (int i = 1; i < 8; i++) send({63'b0, bits[i]}, '0, 0, "R7 feedback bit encrypt");
    dir_i = 1'b1;
    for (int i = 0; i < 8; i++) send({63'b0, cap[i][0]}, {63'b0, bits[i]}, 1, "R7 feedback bit decrypt");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11 one result per request", exp_q.size(), 64'd0);
    finish_run();
  end
endmodule